// File: doc/BRIEF.md
# Space-Vector Sector and Dwell-Time Calculator

This block belongs to a space-vector modulator for a three-phase inverter. Once per switching period, control logic presents a sampled reference voltage vector. The vector is given as a modulation index and an electrical angle, and the block captures it on a one-cycle sample strobe. From that sample the block finds which of the six 60-degree sectors the vector lies in. It then computes how long each of the two active switching states that bound that sector is applied, and how long the null state fills the rest of the period. All three times are expressed in clock ticks of the switching period.

The angle is reduced to its offset inside the sector, and the two sine values come from a quarter-wave table. When the reference is too long to be built inside the hexagon, the computed null time goes negative. In that case the block keeps the direction of the reference: it scales both active times in proportion so that together they fill the whole period, and it sets the null time to zero. Results are registered and announced by a one-cycle valid pulse a fixed number of cycles after the strobe. They stay on the outputs until the next result.

Top module: `svm_dwell_calc`

## Requirements
- R1: `sector_no` = floor(`elec_ang` * 6 / 65536) + 1, always in the range 1..6. `elec_ang` is an unsigned fraction of a full electrical revolution, so 65536 corresponds to 360 degrees.
- R2: Let m = `mod_idx` / 32768 (unsigned Q1.15), T = `period_ticks`, and let θ' be the angle inside the sector. In linear mode, `t_act1` ≈ T·m·(2/√3)·sin(60°−θ') and `t_act2` ≈ T·m·(2/√3)·sin(θ'), each within 8 ticks.
- R3: `t_act1 + t_act2 + t_null` equals T exactly on every result. In linear mode, `t_null` ≈ T − t1 − t2 and is within 8 ticks of that ideal value.
- R4: Overmodulation is entered when T − t1 − t2 from R2 would be negative. Then `t_null` = 0, `t_act1` ≈ T·sin(60°−θ')/(sin(60°−θ')+sin θ') within 8 ticks, and `t_act2` = T − `t_act1`.
- R5: At m = 0.866 with the vector in the middle of a sector, `t_null` is within 8 ticks of zero and both active times are within 8 ticks of T/2.
- R6: `out_vld` is high for exactly one cycle. It is first seen high 40 rising edges after the edge that samples `smp_stb`.
- R7: The outputs change only together with `out_vld`. Changes on `mod_idx`, `elec_ang` or `period_ticks` without a strobe leave them unchanged.
- R8: A synchronous active-high `rst` clears `out_vld`, `sector_no` and the three times to zero, and it discards any calculation in flight.
- R9: When the angle lies exactly on the start of a sector (θ' = 0), `t_act2` is exactly 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_stb | input | 1 | One-cycle strobe that captures a new reference sample |
| mod_idx | input | 16 | Modulation index, unsigned Q1.15 |
| elec_ang | input | 16 | Electrical angle as an unsigned fraction of one revolution |
| period_ticks | input | 16 | Switching period length in clock ticks |
| out_vld | output | 1 | One-cycle pulse marking a new result |
| sector_no | output | 3 | Sector number, 1..6 |
| t_act1 | output | 16 | Dwell time of the first bounding active state, in ticks |
| t_act2 | output | 16 | Dwell time of the second bounding active state, in ticks |
| t_null | output | 16 | Dwell time of the null state, in ticks |

## Verification
The assertions rely on two properties of the input. First, consecutive strobes are at least 40 cycles apart, because the single shared divider must be idle when a new sample reaches it. Second, `period_ticks` is nonzero and `mod_idx` stays below 2.0, so the intermediate products keep within their widths. The stimulus meets both conditions: it raises the strobe only after the previous result has been seen, it uses periods between 800 and 2000 ticks, and it uses modulation indices up to 1.15. It also alters the inputs freely between strobes to show that such changes have no effect.

// File: rtl/svm_pkg.sv
package svm_pkg;

  typedef logic [2:0] sector_t;

  // 60 degrees on a phase scale where 2^16 spans 90 degrees
  localparam int unsigned SIXTY_PH = 43691;
  // 2/sqrt(3) in Q2.14
  localparam int unsigned INV_SIN60_Q14 = 18919;

  function automatic int sine_entry(input int idx, input int addr_w, input int amp);
    real ang;
    ang = (3.14159265358979 / 2.0) * real'(idx) / real'(2 ** addr_w);
    return $rtoi(real'(amp) * $sin(ang) + 0.5);
  endfunction

endpackage

// File: rtl/svm_sector_split.sv
module svm_sector_split
  import svm_pkg::*;
#(
  parameter int ANG_W = 16
) (
  input  logic [ANG_W-1:0] ang,
  output sector_t          sector,
  output logic [ANG_W-1:0] frac
);

  localparam int PW = ANG_W + 3;

  logic [PW-1:0] prod;

  // angle times six: integer part is the sector, fraction is position inside it
  assign prod   = PW'(ang) * PW'(6);
  assign sector = sector_t'(prod >> ANG_W) + sector_t'(1);
  assign frac   = ANG_W'(prod);

endmodule

// File: rtl/svm_sine_rom.sv
module svm_sine_rom
  import svm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic [ADDR_W:0]          addr_a,
  input  logic [ADDR_W:0]          addr_b,
  output logic signed [DATA_W-1:0] q_a,
  output logic signed [DATA_W-1:0] q_b
);

  localparam int DEPTH = 2 ** ADDR_W + 1;
  localparam int AMP   = 2 ** (DATA_W - 1) - 1;

  logic signed [DATA_W-1:0] rom [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      rom[i] = DATA_W'(sine_entry(i, ADDR_W, AMP));
    end
  end

  always_ff @(posedge clk) begin
    q_a <= rom[addr_a];
    q_b <= rom[addr_b];
  end

endmodule

// File: rtl/svm_ratio_div.sv
module svm_ratio_div #(
  parameter int NUM_W = 34,
  parameter int DEN_W = 19
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic [NUM_W-1:0] quot,
  output logic             done
);

  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [NUM_W-1:0] nsh;
  logic [DEN_W-1:0] dreg;
  logic [DEN_W-1:0] rem;
  logic [CNT_W-1:0] cnt;
  logic             busy;
  logic [DEN_W:0]   trial;

  assign trial = {rem, nsh[NUM_W-1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
      rem  <= '0;
      quot <= '0;
      nsh  <= '0;
      dreg <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        nsh  <= num;
        dreg <= den;
        rem  <= '0;
        quot <= '0;
        cnt  <= CNT_W'(NUM_W);
        busy <= 1'b1;
      end else if (busy) begin
        if (trial >= {1'b0, dreg}) begin
          rem  <= DEN_W'(trial - {1'b0, dreg});
          quot <= {quot[NUM_W-2:0], 1'b1};
        end else begin
          rem  <= trial[DEN_W-1:0];
          quot <= {quot[NUM_W-2:0], 1'b0};
        end
        nsh <= nsh << 1;
        cnt <= cnt - CNT_W'(1);
        if (cnt == CNT_W'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // samples must be spaced so the divider is idle when a new one arrives
  p_start_idle_r6: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy);

  p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // partial remainder always stays below the divisor (R4 ratio path)
  p_rem_bound_r4: assert property (@(posedge clk) disable iff (rst)
    (busy && dreg != '0) |-> (rem < dreg));

endmodule

// File: rtl/svm_dwell_calc.sv
module svm_dwell_calc
  import svm_pkg::*;
#(
  parameter int ANG_W  = 16,
  parameter int MAG_W  = 16,
  parameter int PER_W  = 16,
  parameter int LUT_AW = 8,
  parameter int SIN_W  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             smp_stb,
  input  logic [MAG_W-1:0] mod_idx,
  input  logic [ANG_W-1:0] elec_ang,
  input  logic [PER_W-1:0] period_ticks,
  output logic             out_vld,
  output logic [2:0]       sector_no,
  output logic [PER_W-1:0] t_act1,
  output logic [PER_W-1:0] t_act2,
  output logic [PER_W-1:0] t_null
);

  localparam int PH_W  = 16;
  localparam int MF    = MAG_W - 1;
  localparam int SF    = SIN_W - 1;
  localparam int U_W   = MAG_W + 1;
  localparam int G_W   = U_W + PER_W - MF;
  localparam int SUM_W = G_W + 1;
  localparam int NUM_W = G_W + PER_W;
  localparam int HALF  = 2 ** (PH_W - LUT_AW - 1);

  // sector split on the live input, captured by the strobe
  sector_t           sec_w;
  logic [ANG_W-1:0]  frac_w;

  svm_sector_split #(.ANG_W(ANG_W)) split_i (
    .ang    (elec_ang),
    .sector (sec_w),
    .frac   (frac_w)
  );

  // stage 1: capture
  logic             v1;
  sector_t          sec1;
  logic [ANG_W-1:0] frac1;
  logic [MAG_W-1:0] mag1;
  logic [PER_W-1:0] per1;

  always_ff @(posedge clk) begin
    if (rst) v1 <= 1'b0;
    else     v1 <= smp_stb;
    if (smp_stb) begin
      sec1  <= sec_w;
      frac1 <= frac_w;
      mag1  <= mod_idx;
      per1  <= period_ticks;
    end
  end

  // table addresses for sin(theta') and sin(60 - theta')
  logic [PH_W-1:0]   ph_a, ph_b;
  logic [LUT_AW:0]   idx_a, idx_b;
  logic signed [SIN_W-1:0] sin_a2, sin_b2;

  assign ph_a  = PH_W'((64'(frac1) * 64'(SIXTY_PH)) >> ANG_W);
  assign ph_b  = PH_W'(SIXTY_PH) - ph_a;
  assign idx_a = (LUT_AW + 1)'((32'(ph_a) + 32'(HALF)) >> (PH_W - LUT_AW));
  assign idx_b = (LUT_AW + 1)'((32'(ph_b) + 32'(HALF)) >> (PH_W - LUT_AW));

  svm_sine_rom #(.ADDR_W(LUT_AW), .DATA_W(SIN_W)) rom_i (
    .clk    (clk),
    .addr_a (idx_a),
    .addr_b (idx_b),
    .q_a    (sin_a2),
    .q_b    (sin_b2)
  );

  // stage 2: scaled index, table read in parallel
  logic             v2;
  sector_t          sec2;
  logic [PER_W-1:0] per2;
  logic [U_W-1:0]   u2;

  always_ff @(posedge clk) begin
    if (rst) v2 <= 1'b0;
    else     v2 <= v1;
    sec2 <= sec1;
    per2 <= per1;
    u2   <= U_W'((64'(mag1) * 64'(INV_SIN60_Q14)) >> 14);
  end

  // stage 3: amplitude in ticks
  logic                    v3;
  sector_t                 sec3;
  logic [PER_W-1:0]        per3;
  logic [G_W-1:0]          g3;
  logic signed [SIN_W-1:0] sa3, sb3;

  always_ff @(posedge clk) begin
    if (rst) v3 <= 1'b0;
    else     v3 <= v2;
    sec3 <= sec2;
    per3 <= per2;
    g3   <= G_W'((64'(u2) * 64'(per2)) >> MF);
    sa3  <= sin_a2;
    sb3  <= sin_b2;
  end

  // stage 4: raw active times
  logic             v4;
  sector_t          sec4;
  logic [PER_W-1:0] per4;
  logic [G_W-1:0]   t1r4, t2r4;

  always_ff @(posedge clk) begin
    if (rst) v4 <= 1'b0;
    else     v4 <= v3;
    sec4 <= sec3;
    per4 <= per3;
    t1r4 <= G_W'((64'(g3) * 64'(sb3)) >> SF);
    t2r4 <= G_W'((64'(g3) * 64'(sa3)) >> SF);
  end

  // stage 5: null time, sum and ratio numerator
  logic             v5;
  sector_t          sec5;
  logic [PER_W-1:0] per5;
  logic [G_W-1:0]   t1r5, t2r5;
  logic [SUM_W-1:0] sum5;
  logic [SUM_W:0]   t0raw5;
  logic [NUM_W-1:0] num5;

  always_ff @(posedge clk) begin
    if (rst) v5 <= 1'b0;
    else     v5 <= v4;
    sec5   <= sec4;
    per5   <= per4;
    t1r5   <= t1r4;
    t2r5   <= t2r4;
    sum5   <= SUM_W'(t1r4) + SUM_W'(t2r4);
    t0raw5 <= (SUM_W + 1)'(per4) - ((SUM_W + 1)'(t1r4) + (SUM_W + 1)'(t2r4));
    num5   <= NUM_W'(64'(t1r4) * 64'(per4));
  end

  // proportional share of the period, always run for fixed latency
  logic [NUM_W-1:0] quot;
  logic             div_done;

  svm_ratio_div #(.NUM_W(NUM_W), .DEN_W(SUM_W)) div_i (
    .clk   (clk),
    .rst   (rst),
    .start (v5),
    .num   (num5),
    .den   (sum5),
    .quot  (quot),
    .done  (div_done)
  );

  logic om_sel;
  assign om_sel = t0raw5[SUM_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld   <= 1'b0;
      sector_no <= '0;
      t_act1    <= '0;
      t_act2    <= '0;
      t_null    <= '0;
    end else begin
      out_vld <= div_done;
      if (div_done) begin
        sector_no <= sec5;
        if (om_sel) begin
          t_act1 <= PER_W'(quot);
          t_act2 <= per5 - PER_W'(quot);
          t_null <= '0;
        end else begin
          t_act1 <= PER_W'(t1r5);
          t_act2 <= PER_W'(t2r5);
          t_null <= PER_W'(t0raw5);
        end
      end
    end
  end

  p_sector_range_r1: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> (sector_no >= 3'd1 && sector_no <= 3'd6));

  p_sum_period_r3: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> ((PER_W + 2)'(t_act1) + (PER_W + 2)'(t_act2) + (PER_W + 2)'(t_null)
                 == (PER_W + 2)'(per5)));

  p_overmod_null_r4: assert property (@(posedge clk) disable iff (rst)
    (out_vld && om_sel) |-> (t_null == '0));

  p_vld_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    out_vld |=> !out_vld);

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !div_done |=> $stable({sector_no, t_act1, t_act2, t_null}));

endmodule

// File: tb/svm_dwell_calc_tb_top.sv
`timescale 1ns/1ps
module svm_dwell_calc_tb_top;

  localparam real PI  = 3.14159265358979;
  localparam real TOL = 8.0;
  localparam int  LAT = 40;

  typedef struct packed {
    logic [15:0] ang;
    logic [15:0] mag;
    logic [15:0] per;
    logic [2:0]  sec;
    logic [1:0]  kind; // 0 linear, 1 overmod, 2 mid-sector limit, 3 sector start
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{16'd0,     16'd16384, 16'd1000, 3'd1, 2'd3},
    '{16'd5461,  16'd16384, 16'd1000, 3'd1, 2'd0},
    '{16'd16384, 16'd22938, 16'd1200, 3'd2, 2'd0},
    '{16'd27307, 16'd9830,  16'd800,  3'd3, 2'd0},
    '{16'd38229, 16'd19661, 16'd1000, 3'd4, 2'd0},
    '{16'd49152, 16'd26214, 16'd1000, 3'd5, 2'd0},
    '{16'd60075, 16'd13107, 16'd2000, 3'd6, 2'd0},
    '{16'd10922, 16'd16384, 16'd1000, 3'd1, 2'd0},
    '{16'd10923, 16'd16384, 16'd1000, 3'd2, 2'd0},
    '{16'd65535, 16'd16384, 16'd1000, 3'd6, 2'd0},
    '{16'd5461,  16'd28377, 16'd1000, 3'd1, 2'd2},
    '{16'd5461,  16'd32768, 16'd1000, 3'd1, 2'd1},
    '{16'd20000, 16'd36045, 16'd1000, 3'd2, 2'd1},
    '{16'd3000,  16'd37683, 16'd1500, 3'd1, 2'd1},
    '{16'd32768, 16'd19661, 16'd1000, 3'd4, 2'd3},
    '{16'd0,     16'd0,     16'd1000, 3'd1, 2'd0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        smp_stb = 1'b0;
  logic [15:0] mod_idx = '0;
  logic [15:0] elec_ang = '0;
  logic [15:0] period_ticks = '0;
  logic        out_vld;
  logic [2:0]  sector_no;
  logic [15:0] t_act1, t_act2, t_null;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  svm_dwell_calc dut_i (
    .clk          (clk),
    .rst          (rst),
    .smp_stb      (smp_stb),
    .mod_idx      (mod_idx),
    .elec_ang     (elec_ang),
    .period_ticks (period_ticks),
    .out_vld      (out_vld),
    .sector_no    (sector_no),
    .t_act1       (t_act1),
    .t_act2       (t_act2),
    .t_null       (t_null)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_near(input string req, input string what, input int act, input real e);
    real d;
    d = real'(act) - e;
    if (d < 0.0) d = -d;
    chk(d <= TOL, req, what, act, $rtoi(e + 0.5));
  endtask

  task automatic run_vec(input vec_t v);
    real th, sa, sb, k, e1, e2, e0;
    int lat;
    string tg;
    th = real'((32'(v.ang) * 6) % 65536) / 65536.0 * (PI / 3.0);
    sa = $sin(th);
    sb = $sin(PI / 3.0 - th);
    k  = real'(v.mag) / 32768.0 * 2.0 / $sqrt(3.0) * real'(v.per);
    e1 = k * sb;
    e2 = k * sa;
    e0 = real'(v.per) - e1 - e2;
    if (e0 < 0.0) begin
      e1 = real'(v.per) * sb / (sa + sb);
      e2 = real'(v.per) - e1;
      e0 = 0.0;
    end
    case (v.kind)
      2'd1:    tg = "R4";
      2'd2:    tg = "R5";
      2'd3:    tg = "R9";
      default: tg = "R2";
    endcase

    @(negedge clk);
    smp_stb = 1'b1; elec_ang = v.ang; mod_idx = v.mag; period_ticks = v.per;
    @(posedge clk);
    @(negedge clk);
    smp_stb = 1'b0; elec_ang = ~v.ang; mod_idx = 16'h1234; period_ticks = 16'd77;
    lat = 0;
    do begin
      @(posedge clk);
      lat++;
      @(negedge clk);
    end while (!out_vld && lat < 100);

    chk(lat == LAT, "R6", "latency", lat, LAT);
    chk(sector_no == v.sec, "R1", "sector", sector_no, v.sec);
    chk_near(tg, "t_act1", int'(t_act1), e1);
    chk_near(tg, "t_act2", int'(t_act2), e2);
    if (v.kind == 2'd1) chk(t_null == 16'd0, "R4", "t_null zero", t_null, 0);
    else                chk_near("R3", "t_null", int'(t_null), e0);
    chk(32'(t_act1) + 32'(t_act2) + 32'(t_null) == 32'(v.per), "R3", "sum",
        32'(t_act1) + 32'(t_act2) + 32'(t_null), v.per);
    if (v.kind == 2'd3) chk(t_act2 == 16'd0, "R9", "t_act2 exact", t_act2, 0);
    @(posedge clk);
    @(negedge clk);
    chk(!out_vld, "R6", "pulse width", out_vld, 0);
  endtask

  initial begin
    logic [15:0] h1, h2, h0;
    logic [2:0]  hs;
    bit seen;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(!out_vld, "R8", "reset vld", out_vld, 0);
    chk(t_act1 == 0 && t_act2 == 0 && t_null == 0 && sector_no == 0, "R8", "reset outputs",
        {sector_no, t_act1}, 0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R7: inputs wander without a strobe
    hs = sector_no; h1 = t_act1; h2 = t_act2; h0 = t_null;
    seen = 1'b0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      elec_ang = 16'(i * 1111); mod_idx = 16'(i * 777); period_ticks = 16'(500 + i);
      if (out_vld) seen = 1'b1;
    end
    chk(!seen, "R7", "no spurious valid", seen, 0);
    chk(t_act1 == h1, "R7", "t_act1 held", t_act1, h1);
    chk(t_act2 == h2, "R7", "t_act2 held", t_act2, h2);
    chk(t_null == h0 && sector_no == hs, "R7", "t_null/sector held", t_null, h0);

    // R8: reset during a calculation discards it
    @(negedge clk);
    smp_stb = 1'b1; elec_ang = 16'd20000; mod_idx = 16'd20000; period_ticks = 16'd1000;
    @(negedge clk);
    smp_stb = 1'b0;
    repeat (12) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(t_act1 == 0 && t_act2 == 0 && t_null == 0 && sector_no == 0, "R8", "cleared outputs",
        t_act1, 0);
    seen = 1'b0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (out_vld) seen = 1'b1;
    end
    chk(!seen, "R8", "in-flight result dropped", seen, 0);

    // recovery after reset
    run_vec(VECS[4]);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL R6 watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule